// File: doc/BRIEF.md
# Sequence-Unlocked State Gate with Resume

This block guards a piece of protected sequential logic. After reset it is locked. While it is locked it drives a nonzero corruption mask, and each bit of that mask is XORed onto a chosen internal node of the protected logic, so the logic's results are wrong. To unlock it, a fixed-length sequence of key words must arrive on the ordinary data input, one word per clock. Each locked entry point has its own sequence. When the whole sequence is accepted, the block enters its single authenticated state and clears the mask.

While authenticated, an external scheduler can raise a back-jump request together with a target locked state. The block then captures the protected logic's next-state value into a holding register and returns to locked mode at that target. It stays there until the target's own key sequence is accepted. On re-entry to the authenticated state it pulses a load strobe, and the protected logic reloads the held value and carries on from where it stopped.

Top module: `seq_lock_gate`

## Requirements
- R1: After reset the block is locked at entry state 0. `authenticated` is 0, `restoreLoad` is 0, `restoredState` equals the RESET_STATE parameter (0), and `corruptMask` shows the state-0 value.
- R2: While `authenticated` is 1, every bit of `corruptMask` is 0.
- R3: While locked, `corruptMask` depends only on the current entry state. It is never 0, and it differs between entry states. With a 3-bit mask (bit2 bit1 bit0) the values are: state0=110, state1=101, state2=111, state3=011, state4=001 (state5=010, state6=100 if present). For other widths the value is the state index plus 1.
- R4: The sequence for entry state e is SEQ_LEN words long (default 8). Word i is the low KEY_W bits of KEY_SEED XOR (37e + 11i + 3ei), with default seed 0xA5. The words must arrive on consecutive cycles. `authenticated` rises in the cycle after the last word is sampled.
- R5: A word that does not match the expected one resets the progress to word 0. The mismatching word itself is not re-tested as word 0.
- R6: A back-jump request while authenticated makes the block locked at `bjTarget` in the next cycle. A target of N_LOCK or above selects state 0. A back-jump request while locked has no effect.
- R7: On an accepted back-jump the value on `protNext` is captured, and `restoredState` holds it from then on. `restoreLoad` is 1 only in the first authenticated cycle after each accepted sequence.
- R8: The first unlock after reset restores RESET_STATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyIn | input | KEY_W | Primary data word, also used as the key stream |
| bjReq | input | 1 | Back-jump request from the scheduler |
| bjTarget | input | IDX_W | Locked entry state to jump to |
| protNext | input | STATE_W | Next-state value of the protected logic |
| authenticated | output | 1 | High in the functional state |
| corruptMask | output | MASK_W | Mask XORed onto protected internal nodes |
| restoredState | output | STATE_W | Held protected state to reload |
| restoreLoad | output | 1 | One-cycle strobe to reload `restoredState` |

## Verification
The block is first unlocked with clean sequences from reset and from several back-jump targets. This shows that each entry point accepts only its own words and produces its own mask. Sequences broken by a wrong word in the middle, at the last position, and followed at once by a word-0 value separate "restart from zero" from "resume" and from "re-test the bad word". Back-jump requests sent while locked, and targets out of range, separate an ignored request from a taken one. A long run of random key words, with correct words mixed in and random jumps, is compared every clock against a behavioural model of mode, progress, mask and held state.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  typedef enum logic {
    MODE_LOCKED = 1'b0,
    MODE_AUTH   = 1'b1
  } lockMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic saveEn;     // capture protected next state
    logic restoreEn;  // sequence accepted this cycle
  } lockStrobe_t;

  // expected key word i of the sequence for entry state e
  function automatic int unsigned keyWordCalc(int unsigned seed, int unsigned e, int unsigned i);
    return seed ^ (e * 37 + i * 11 + e * i * 3);
  endfunction

  // locked-state mask value, nonzero and distinct per entry state
  function automatic int unsigned maskCalc(int unsigned w, int unsigned e);
    int unsigned v;
    v = e + 1;
    if (w == 3) begin
      case (e)
        0: v = 6;
        1: v = 5;
        2: v = 7;
        3: v = 3;
        4: v = 1;
        5: v = 2;
        6: v = 4;
        default: v = 1;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
  import seq_lock_pkg::*;
#(
  parameter int N_LOCK  = 5,
  parameter int SEQ_LEN = 8,
  parameter int IDX_W   = 3,
  parameter int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyMatch,
  input  logic              bjReq,
  input  logic [IDX_W-1:0]  bjTarget,
  output lockMode_e         mode,
  output logic [IDX_W-1:0]  lockIdx,
  output logic [STEP_W-1:0] step,
  output lockStrobe_t       strobe
);

  logic             lastStep;
  logic             accept;
  logic             jump;
  logic [IDX_W-1:0] targetIdx;

  assign lastStep  = (step == STEP_W'(SEQ_LEN - 1));
  assign accept    = (mode == MODE_LOCKED) && keyMatch && lastStep;
  assign jump      = (mode == MODE_AUTH) && bjReq;
  assign targetIdx = (32'(bjTarget) < N_LOCK) ? bjTarget : '0;

  assign strobe.saveEn    = jump;
  assign strobe.restoreEn = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_LOCKED;
      lockIdx <= '0;
      step    <= '0;
    end else if (mode == MODE_LOCKED) begin
      if (keyMatch) begin
        if (lastStep) begin
          mode <= MODE_AUTH;
          step <= '0;
        end else begin
          step <= step + STEP_W'(1);
        end
      end else begin
        step <= '0;
      end
    end else if (bjReq) begin
      mode    <= MODE_LOCKED;
      lockIdx <= targetIdx;
      step    <= '0;
    end
  end

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCKED && !accept) |=> (mode == MODE_LOCKED)); // R4
  AST_MISS_CLEARS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCKED && !keyMatch) |=> (step == '0)); // R5
  AST_JUMP_LANDS_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    jump |=> (mode == MODE_LOCKED && step == '0)); // R6
  AST_LOCKED_IDX_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCKED) |=> (lockIdx == $past(lockIdx))); // R6

endmodule

// File: rtl/seq_lock_data.sv
module seq_lock_data
  import seq_lock_pkg::*;
#(
  parameter int KEY_W       = 8,
  parameter int STATE_W     = 8,
  parameter int MASK_W      = 3,
  parameter int N_LOCK      = 5,
  parameter int SEQ_LEN     = 8,
  parameter int KEY_SEED    = 'hA5,
  parameter int RESET_STATE = 0,
  parameter int IDX_W       = 3,
  parameter int STEP_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [KEY_W-1:0]   keyIn,
  input  logic [STATE_W-1:0] protNext,
  input  lockMode_e          mode,
  input  logic [IDX_W-1:0]   lockIdx,
  input  logic [STEP_W-1:0]  step,
  input  lockStrobe_t        strobe,
  output logic               keyMatch,
  output logic [MASK_W-1:0]  corruptMask,
  output logic [STATE_W-1:0] restoredState,
  output logic               restoreLoad
);

  logic [KEY_W-1:0]   keyRom  [N_LOCK][SEQ_LEN];
  logic [MASK_W-1:0]  maskRom [N_LOCK];
  logic [KEY_W-1:0]   expWord;
  logic [MASK_W-1:0]  stateMask;
  logic [STATE_W-1:0] savedState;

  for (genvar e = 0; e < N_LOCK; e++) begin : g_entry
    assign maskRom[e] = MASK_W'(maskCalc(MASK_W, e));
    for (genvar i = 0; i < SEQ_LEN; i++) begin : g_word
      assign keyRom[e][i] = KEY_W'(keyWordCalc(KEY_SEED, e, i));
    end
  end

  if (N_LOCK >= (1 << MASK_W)) begin : g_bad_mask
    $error("mask too narrow for distinct nonzero per-state values");
  end

  always_comb begin
    expWord   = '0;
    stateMask = '0;
    for (int e = 0; e < N_LOCK; e++) begin
      if (lockIdx == IDX_W'(e)) begin
        stateMask = maskRom[e];
        for (int i = 0; i < SEQ_LEN; i++) begin
          if (step == STEP_W'(i)) expWord = keyRom[e][i];
        end
      end
    end
  end

  assign keyMatch      = (keyIn == expWord);
  assign corruptMask   = (mode == MODE_AUTH) ? '0 : stateMask;
  assign restoredState = savedState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedState  <= STATE_W'(RESET_STATE);
      restoreLoad <= 1'b0;
    end else begin
      restoreLoad <= strobe.restoreEn;
      if (strobe.saveEn) savedState <= protNext;
    end
  end

  AST_SAVED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveEn |=> $stable(savedState)); // R7
  AST_SAVE_CAPTURES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.saveEn |=> (savedState == $past(protNext))); // R7

endmodule

// File: rtl/seq_lock_gate.sv
module seq_lock_gate
  import seq_lock_pkg::*;
#(
  parameter int KEY_W       = 8,
  parameter int STATE_W     = 8,
  parameter int MASK_W      = 3,
  parameter int N_LOCK      = 5,
  parameter int SEQ_LEN     = 8,
  parameter int KEY_SEED    = 'hA5,
  parameter int RESET_STATE = 0,
  localparam int IDX_W      = (N_LOCK > 1) ? $clog2(N_LOCK) : 1,
  localparam int STEP_W     = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [KEY_W-1:0]   keyIn,
  input  logic               bjReq,
  input  logic [IDX_W-1:0]   bjTarget,
  input  logic [STATE_W-1:0] protNext,
  output logic               authenticated,
  output logic [MASK_W-1:0]  corruptMask,
  output logic [STATE_W-1:0] restoredState,
  output logic               restoreLoad
);

  lockMode_e         mode;
  logic [IDX_W-1:0]  lockIdx;
  logic [STEP_W-1:0] step;
  lockStrobe_t       strobe;
  logic              keyMatch;

  seq_lock_ctrl #(
    .N_LOCK(N_LOCK), .SEQ_LEN(SEQ_LEN), .IDX_W(IDX_W), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .keyMatch(keyMatch), .bjReq(bjReq),
    .bjTarget(bjTarget), .mode(mode), .lockIdx(lockIdx), .step(step),
    .strobe(strobe)
  );

  seq_lock_data #(
    .KEY_W(KEY_W), .STATE_W(STATE_W), .MASK_W(MASK_W), .N_LOCK(N_LOCK),
    .SEQ_LEN(SEQ_LEN), .KEY_SEED(KEY_SEED), .RESET_STATE(RESET_STATE),
    .IDX_W(IDX_W), .STEP_W(STEP_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .protNext(protNext), .mode(mode),
    .lockIdx(lockIdx), .step(step), .strobe(strobe), .keyMatch(keyMatch),
    .corruptMask(corruptMask), .restoredState(restoredState),
    .restoreLoad(restoreLoad)
  );

  assign authenticated = (mode == MODE_AUTH);

  AST_AUTH_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    authenticated |-> (corruptMask == '0)); // R2
  AST_LOCK_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    !authenticated |-> (corruptMask != '0)); // R3
  AST_RESTORE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    restoreLoad |-> (authenticated && !$past(authenticated))); // R7
  AST_JUMP_DROPS_AUTH: assert property (@(posedge clk) disable iff (!rstN)
    (authenticated && bjReq) |=> (!authenticated && !restoreLoad)); // R6

endmodule

// File: tb/seq_lock_gate_bench.sv
`timescale 1ns/1ps
module seq_lock_gate_bench;

  localparam int SEQ = 8;
  localparam int NL  = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] keyIn = '0;
  logic       bjReq = 1'b0;
  logic [2:0] bjTarget = '0;
  logic [7:0] protNext = '0;
  logic       authenticated;
  logic [2:0] corruptMask;
  logic [7:0] restoredState;
  logic       restoreLoad;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  bit refAuth = 0;
  int refIdx = 0;
  int refStep = 0;
  int refSaved = 0;
  bit refRestore = 0;

  always #2 clk = ~clk;

  seq_lock_gate u_seq_lock_gate (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .bjReq(bjReq), .bjTarget(bjTarget),
    .protNext(protNext), .authenticated(authenticated), .corruptMask(corruptMask),
    .restoredState(restoredState), .restoreLoad(restoreLoad)
  );

  function automatic int word(int e, int i);
    return (165 ^ (e * 37 + i * 11 + e * i * 3)) & 255;
  endfunction

  function automatic int maskOf(int e);
    case (e)
      0: return 6;
      1: return 5;
      2: return 7;
      3: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic check(string tag);
    int em;
    em = refAuth ? 0 : maskOf(refIdx);
    nChecks++;
    if (authenticated !== refAuth || corruptMask !== 3'(em) ||
        restoreLoad !== refRestore || restoredState !== 8'(refSaved)) begin
      nFails++;
      $display("FAIL %s auth=%0b mask=%0d load=%0b held=%0h expected auth=%0b mask=%0d load=%0b held=%0h",
               tag, authenticated, corruptMask, restoreLoad, restoredState,
               refAuth, em, refRestore, refSaved);
    end
  endtask

  task automatic model(int k, bit bj, int t, int p);
    if (!refAuth) begin
      refRestore = 0;
      if (k == word(refIdx, refStep)) begin
        if (refStep == SEQ - 1) begin
          refAuth = 1; refRestore = 1; refStep = 0;
        end else refStep++;
      end else refStep = 0;
    end else begin
      refRestore = 0;
      if (bj) begin
        refAuth = 0; refIdx = (t < NL) ? t : 0; refStep = 0; refSaved = p;
      end
    end
  endtask

  task automatic cyc(int k, bit bj, int t, int p, string tag);
    keyIn = 8'(k); bjReq = bj; bjTarget = 3'(t); protNext = 8'(p);
    @(posedge clk);
    model(k, bj, t, p);
    @(negedge clk);
    check(tag);
  endtask

  task automatic unlock(int e, string tag);
    for (int i = 0; i < SEQ; i++) cyc(word(e, i), 0, 0, 8'h11 * i, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset state");

    // garbage before unlocking keeps the lock
    cyc(8'h00, 0, 0, 0, "R4 garbage");
    cyc(8'hFF, 1, 3, 9, "R6 request ignored while locked");
    unlock(0, "R4 unlock entry 0");
    check("R8 first restore holds reset value");
    cyc(8'h12, 0, 0, 1, "R2 auth mask clear");
    cyc(8'h34, 0, 0, 2, "R7 load strobe one cycle");
    cyc(8'h00, 1, 2, 8'h3C, "R6 jump to entry 2");
    check("R3 entry 2 mask");

    // broken sequence on entry 2
    for (int i = 0; i < 4; i++) cyc(word(2, i), 0, 0, 0, "R5 prefix");
    cyc(word(2, 4) ^ 1, 0, 0, 0, "R5 wrong word");
    cyc(word(2, 5), 0, 0, 0, "R5 no resume after miss");
    cyc(word(2, 0), 1, 1, 0, "R6 locked request ignored");
    for (int i = 1; i < SEQ - 1; i++) cyc(word(2, i), 0, 0, 0, "R5 restart");
    cyc(word(2, SEQ - 1) ^ 8'h80, 0, 0, 0, "R5 wrong last word");
    unlock(2, "R7 unlock entry 2 restores 3C");
    cyc(0, 1, 7, 8'h5A, "R6 out of range target");
    unlock(0, "R7 restore 5A");

    // visit every entry state
    for (int e = 1; e < NL; e++) begin
      cyc(0, 1, e, 8'h40 + e, "R6 jump");
      check("R3 per-state mask");
      cyc(word((e + 1) % NL, 0), 0, 0, 0, "R4 other entry key rejected");
      unlock(e, "R4 unlock own entry");
    end

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int k;
      int r;
      r = int'($urandom_range(0, 9));
      k = (r < 7 && !refAuth) ? word(refIdx, refStep) : int'($urandom_range(0, 255));
      cyc(k, ($urandom_range(0, 7) == 0), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 255)), "R4 random stream");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule